// File: doc/BRIEF.md
# Strobed Input Channel with Buffer-Full Handshake

This block receives bytes from a peripheral that has no shared clock. The peripheral puts a byte on its data lines and pulls an active-low strobe. The channel captures the byte and raises a buffer-full flag back toward the peripheral. When the peripheral lets go of the strobe, the channel can request an interrupt from the processor, provided interrupt requests are enabled. The processor reads the byte with an active-low read strobe. The start of that read withdraws the interrupt request, and the end of the read empties the buffer. The peripheral then knows it may send the next byte.

Strobe, read strobe and data are all brought into the system clock through two-flop synchronizers, and every edge is found on the synchronized copies. The interrupt-enable bit is written with a single-bit set/reset command, which names a bit index and the value to write. A four-bit status word lets the processor poll the channel instead of waiting for an interrupt.

Top module: `strobe_in_channel`

## Requirements
- R1: While reset is held, and right after it, `full_o`, `irq_o` and `rd_data_o` are 0, the interrupt enable is 0, and `status_o` is 4'b0001.
- R2: A falling strobe is driven before a clock edge. On the third rising clock edge after that, `rd_data_o` holds the byte that was on `per_data_i` at that time. At no other time does `rd_data_o` change.
- R3: `full_o` rises on the third rising clock edge after the strobe falls. It then stays high until the processor read ends.
- R4: `irq_o` is high exactly when the registered terms of the previous cycle were all true: the enable is set, the buffer is full, the synchronized strobe is released, and no read is in progress or ending. After the strobe is released with the buffer full and the enable set, `irq_o` rises on the third rising edge.
- R5: A falling read strobe forces `irq_o` low by the third rising clock edge after it, while `full_o` stays high.
- R6: A rising read strobe clears `full_o` on the third rising clock edge after it.
- R7: A cycle with `bit_cmd_valid_i` high and `bit_cmd_idx_i` equal to IE_POS (default 4) writes `bit_cmd_val_i` into the enable. A command with any other index leaves the enable unchanged.
- R8: A second strobe that arrives while the buffer is still full overwrites `rd_data_o` with the new byte, and `full_o` stays high. If a strobe falls in the same cycle that a read ends, the strobe wins.
- R9: `status_o` bit 0 is the synchronized strobe level (1 = released), bit 1 is buffer-full, bit 2 is the enable and bit 3 is the interrupt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| per_data_i | input | DATA_W | Peripheral data, asynchronous |
| per_stb_ni | input | 1 | Peripheral strobe, active low, asynchronous |
| cpu_rd_ni | input | 1 | Processor read strobe, active low |
| bit_cmd_valid_i | input | 1 | Single-bit set/reset command valid |
| bit_cmd_idx_i | input | 3 | Bit index named by the command |
| bit_cmd_val_i | input | 1 | Value written by the command |
| rd_data_o | output | DATA_W | Latched byte presented to the processor |
| full_o | output | 1 | Buffer-full flag toward the peripheral |
| irq_o | output | 1 | Interrupt request toward the processor |
| status_o | output | 4 | Pollable status word |

## Verification
The assertions check on every cycle how the internal edge events relate to the flags:
- a strobe fall always fills the buffer;
- a full buffer empties only when a read ends;
- the latch moves only on a strobe fall;
- a read start always withdraws the request;
- the request never follows a cycle with the enable clear;
- a command to any other index leaves the enable alone.

Only the bench scenarios can show the timing and the data seen at the ports:
- the three-edge latency through the synchronizers;
- that the byte captured is the byte actually driven, across a sweep of data values;
- that a second byte overwrites the first;
- the full sweep of command indices and values.

// File: rtl/strobe_in_pkg.sv
package strobe_in_pkg;

  localparam int STAT_W = 4;
  localparam int CMD_IDX_W = 3;

  typedef struct packed {
    logic irq;
    logic ie;
    logic full;
    logic stb_idle;
  } chan_stat_t;

  function automatic chan_stat_t pack_status(input logic stb_idle, input logic full,
                                             input logic ie, input logic irq);
    chan_stat_t s;
    s.stb_idle = stb_idle;
    s.full     = full;
    s.ie       = ie;
    s.irq      = irq;
    return s;
  endfunction

  function automatic logic cmd_hits(input logic [CMD_IDX_W-1:0] idx,
                                    input logic [CMD_IDX_W-1:0] pos);
    return idx == pos;
  endfunction

  function automatic logic irq_term(input logic ie, input logic full, input logic stb_idle,
                                    input logic rd_idle, input logic rd_ending);
    return ie & full & stb_idle & rd_idle & ~rd_ending;
  endfunction

endpackage

// File: rtl/sync_stage.sv
module sync_stage #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= {W{RST_VAL}};
        else if (s == 0) chain_q[s] <= d_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/edge_find.sv
module edge_find #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);

  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else prev_q <= lvl_i;
  end

  assign rise_o = ~prev_q & lvl_i;
  assign fall_o = prev_q & ~lvl_i;

endmodule

// File: rtl/handshake_core.sv
module handshake_core
  import strobe_in_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_s_i,
  input  logic              rd_s_i,
  input  logic [DATA_W-1:0] data_s_i,
  input  logic              ie_i,
  output logic [DATA_W-1:0] latch_o,
  output logic              full_o,
  output logic              irq_o
);

  logic stb_rise, stb_fall, rd_rise, rd_fall;
  logic [DATA_W-1:0] latch_q;
  logic full_q, irq_q, irq_d;

  edge_find #(.RST_VAL(1'b1)) i_stb_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(stb_s_i), .rise_o(stb_rise), .fall_o(stb_fall));
  edge_find #(.RST_VAL(1'b1)) i_rd_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(rd_s_i), .rise_o(rd_rise), .fall_o(rd_fall));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) latch_q <= '0;
    else if (stb_fall) latch_q <= data_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) full_q <= 1'b0;
    else if (stb_fall) full_q <= 1'b1;
    else if (rd_rise) full_q <= 1'b0;
  end

  assign irq_d = irq_term(ie_i, full_q, stb_s_i, rd_s_i, rd_rise);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else irq_q <= irq_d;
  end

  assign latch_o = latch_q;
  assign full_o  = full_q;
  assign irq_o   = irq_q;

  assert_fill_on_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_fall |=> full_q);
  assert_full_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !rd_rise) |=> full_q);
  assert_empty_on_read_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rise && !stb_fall) |=> !full_q);
  assert_latch_moves_only_on_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_fall |=> $stable(latch_q));
  assert_read_start_drops_irq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_fall |=> !irq_q);
  assert_irq_needs_enable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_i |=> !irq_q);
  assert_release_raises_irq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_rise && full_q && ie_i && rd_s_i && !rd_rise) |=> irq_q);

endmodule

// File: rtl/strobe_in_channel.sv
module strobe_in_channel
  import strobe_in_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter int IE_POS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DATA_W-1:0]    per_data_i,
  input  logic                 per_stb_ni,
  input  logic                 cpu_rd_ni,
  input  logic                 bit_cmd_valid_i,
  input  logic [CMD_IDX_W-1:0] bit_cmd_idx_i,
  input  logic                 bit_cmd_val_i,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic                 full_o,
  output logic                 irq_o,
  output logic [STAT_W-1:0]    status_o
);

  localparam logic [CMD_IDX_W-1:0] IE_IDX = CMD_IDX_W'(IE_POS);

  logic [1:0] ctl_s;
  logic [DATA_W-1:0] data_s;
  logic ie_q, ie_hit;
  logic full_w, irq_w;
  chan_stat_t stat_w;

  sync_stage #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_ctl_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({cpu_rd_ni, per_stb_ni}), .q_o(ctl_s));

  sync_stage #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_data_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(per_data_i), .q_o(data_s));

  assign ie_hit = bit_cmd_valid_i & cmd_hits(bit_cmd_idx_i, IE_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ie_q <= 1'b0;
    else if (ie_hit) ie_q <= bit_cmd_val_i;
  end

  handshake_core #(.DATA_W(DATA_W)) i_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .stb_s_i(ctl_s[0]), .rd_s_i(ctl_s[1]),
    .data_s_i(data_s), .ie_i(ie_q), .latch_o(rd_data_o), .full_o(full_w), .irq_o(irq_w));

  assign stat_w   = pack_status(ctl_s[0], full_w, ie_q, irq_w);
  assign status_o = stat_w;
  assign full_o   = full_w;
  assign irq_o    = irq_w;

  assert_other_index_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_cmd_valid_i && bit_cmd_idx_i != IE_IDX) |=> $stable(ie_q));
  assert_enable_written_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ie_hit |=> (ie_q == $past(bit_cmd_val_i)));
  assert_status_flags_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[1] == full_o) && (status_o[3] == irq_o));

endmodule

// File: tb/test_strobe_in_channel.sv
module test_strobe_in_channel;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] pdata = 8'h00;
  logic stb_n = 1'b1;
  logic rd_n = 1'b1;
  logic cv = 1'b0;
  logic [2:0] cidx = 3'd0;
  logic cval = 1'b0;
  logic [7:0] rdata;
  logic full, irq;
  logic [3:0] stat;
  int checks = 0;
  int errors = 0;
  bit ie_exp = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  strobe_in_channel i_strobe_in_channel (
    .clk_i(clk), .rst_ni(rst_n), .per_data_i(pdata), .per_stb_ni(stb_n), .cpu_rd_ni(rd_n),
    .bit_cmd_valid_i(cv), .bit_cmd_idx_i(cidx), .bit_cmd_val_i(cval),
    .rd_data_o(rdata), .full_o(full), .irq_o(irq), .status_o(stat));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_stat(input bit idle, input bit f, input bit e, input bit q);
    return (4'(q) << 3) | (4'(e) << 2) | (4'(f) << 1) | 4'(idle);
  endfunction

  task automatic bitcmd(input logic [2:0] idx, input logic v);
    cv = 1'b1; cidx = idx; cval = v;
    tick(1);
    cv = 1'b0;
    if (idx == 3'd4) ie_exp = v;
    tick(1);
  endtask

  task automatic one_transfer(input logic [7:0] d);
    pdata = d; stb_n = 1'b0;
    tick(3);
    chk(32'(rdata), 32'(d), "R2 byte captured");
    chk(32'(full), 1, "R3 full after strobe");
    chk(32'(irq), 0, "R4 no irq while strobe held");
    chk(32'(stat), 32'(exp_stat(0, 1, ie_exp, 0)), "R9 status strobe low");
    stb_n = 1'b1;
    pdata = ~d;
    tick(3);
    chk(32'(irq), 32'(ie_exp), "R4 irq after release");
    chk(32'(rdata), 32'(d), "R2 latch held after data change");
    chk(32'(stat), 32'(exp_stat(1, 1, ie_exp, ie_exp)), "R9 status full");
    rd_n = 1'b0;
    tick(3);
    chk(32'(irq), 0, "R5 read start drops irq");
    chk(32'(full), 1, "R5 full kept during read");
    rd_n = 1'b1;
    tick(3);
    chk(32'(full), 0, "R6 read end empties");
    chk(32'(irq), 0, "R6 irq stays low after read");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(2);
    chk(32'(full), 0, "R1 full in reset");
    chk(32'(irq), 0, "R1 irq in reset");
    chk(32'(rdata), 0, "R1 data in reset");
    chk(32'(stat), 32'h1, "R1 status in reset");
    rst_n = 1'b1;
    tick(2);
    chk(32'(stat), 32'h1, "R1 status after reset");

    // R7: sweep all indices, set then clear
    for (int v = 1; v >= 0; v--) begin
      for (int i = 0; i < 8; i++) begin
        bitcmd(3'(i), 1'(v));
        chk(32'(stat[2]), 32'(ie_exp), "R7 enable vs index sweep");
      end
    end

    // R2..R6 with enable clear, then set
    for (int e = 0; e < 2; e++) begin
      bitcmd(3'd4, 1'(e));
      for (int k = 0; k < 12; k++) begin
        one_transfer(8'((k * 8'h2B + e * 8'h5A) ^ (k == 11 ? 8'hFF : 8'h00)));
      end
    end
    one_transfer(8'h00);
    one_transfer(8'hFF);

    // R8 overwrite while full
    pdata = 8'hA5; stb_n = 1'b0; tick(3); stb_n = 1'b1; tick(3);
    pdata = 8'h3C; stb_n = 1'b0; tick(3);
    chk(32'(rdata), 32'h3C, "R8 overwrite data");
    chk(32'(full), 1, "R8 full stays set");
    stb_n = 1'b1; tick(3);
    chk(32'(irq), 1, "R8 irq after second release");
    rd_n = 1'b0; tick(3); rd_n = 1'b1; tick(3);
    chk(32'(full), 0, "R6 empty after overwrite read");

    // R4 enabling while full raises irq
    bitcmd(3'd4, 1'b0);
    pdata = 8'h77; stb_n = 1'b0; tick(3); stb_n = 1'b1; tick(3);
    chk(32'(irq), 0, "R4 no irq with enable clear");
    bitcmd(3'd4, 1'b1);
    chk(32'(irq), 1, "R4 irq once enabled while full");
    bitcmd(3'd4, 1'b0);
    chk(32'(irq), 0, "R4 irq drops when disabled");
    rd_n = 1'b0; tick(3); rd_n = 1'b1; tick(3);
    chk(32'(stat), 32'(exp_stat(1, 0, 0, 0)), "R9 idle status");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule